// File: doc/BRIEF.md
# Count-Controlled Iterative Left Shifter

This block is a multicycle logical left shifter that walks through a short control routine instead of using a barrel shifter. A start pulse captures an operand, a small immediate count and a full-width count register. The count is taken from the immediate field. If that field is zero, the count is reloaded from the low bits of the register value instead. The unit then loops: it tests the count for zero, and when the count is not zero it moves the value one place left with a zero entering at the bottom and decrements the count. Once the count reaches zero it writes the shifted value to the result register and pulses done for one cycle.

The interface is a one-shot command, so it has no valid/ready pair and no back-pressure. A start is accepted only when the unit is idle; starts that arrive at other times are dropped. The result is registered and is not consumed by a handshake. It stays on `result_o` until the next completed operation overwrites it. The operand, immediate and register count are all captured on the accepted start, so the driver may change them on any later cycle.

Top module: `shl_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done_o` is 0 and `result_o` is 0.
- R2: When `start_i` is accepted with a non-zero `imm_cnt_i`, the shift amount N is `imm_cnt_i` and `reg_cnt_i` has no effect.
- R3: When `start_i` is accepted with `imm_cnt_i` equal to 0, the shift amount N is `reg_cnt_i[CW-1:0]`; bits above CW-1 of `reg_cnt_i` have no effect.
- R4: Each loop step moves the value one bit toward the MSB, drops the old MSB and puts 0 into bit 0. The final result is therefore `operand << N`, truncated to W bits.
- R5: The count drops by exactly one per step, and it is tested for zero before every step. Counting the accepted start edge as edge 0, `done_o` rises after edge 2N+2 when N comes from the immediate, and after edge 2N+3 when N comes from the register.
- R6: If the effective count is zero, the result equals the operand unshifted. `done_o` then rises after edge 2 (immediate path is never zero) or after edge 3 (register path).
- R7: `done_o` is high for exactly one cycle. `result_o` carries the new value in that same cycle.
- R8: `result_o` does not change except in a cycle where `done_o` is high.
- R9: A `start_i` pulse that arrives while an operation is running is ignored. It changes neither the result nor the completion cycle of the running operation.
- R10: Changing `operand_i`, `imm_cnt_i` or `reg_cnt_i` after the start edge does not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; taken only when idle |
| operand_i | input | W (32) | Value to shift |
| imm_cnt_i | input | CW (5) | Immediate shift count; zero selects the register count |
| reg_cnt_i | input | W (32) | Register holding the fallback count in its low CW bits |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | W (32) | Shifted value, held until the next completion |

## Verification
Several operands are shifted by immediate counts: one, a middle value, sixteen and the maximum of 31. Bits pushed off the top show whether truncation is correct, and the number of cycles to done shows whether the loop runs exactly N times. A zero immediate paired with a register whose upper bits are all ones shows that only the low bits of the register are used and that the extra reload cycle is present. An all-zero effective count separates test-before-shift from test-after-shift. Stray starts and input changes in the middle of an operation show that the command is captured once, at acceptance.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOADR = 3'd1,
    ST_TEST  = 3'd2,
    ST_STEP  = 3'd3,
    ST_WRITE = 3'd4
  } shl_state_e;
endpackage

// File: rtl/shl_seq.sv
// Control sequencer: walks idle -> (reload) -> test/step loop -> write.
module shl_seq
  import shl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       imm_zero_i,
  input  logic       cnt_zero_i,
  output shl_state_e state_o,
  output logic       accept_o,
  output logic       ld_reg_o,
  output logic       step_o,
  output logic       write_o
);
  shl_state_e st_q, st_d;

  assign accept_o = start_i && (st_q == ST_IDLE);
  assign ld_reg_o = (st_q == ST_LOADR);
  assign step_o   = (st_q == ST_STEP);
  assign write_o  = (st_q == ST_WRITE);
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = imm_zero_i ? ST_LOADR : ST_TEST;
      ST_LOADR: st_d = ST_TEST;
      ST_TEST:  st_d = cnt_zero_i ? ST_WRITE : ST_STEP;
      ST_STEP:  st_d = ST_TEST;
      ST_WRITE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/shl_count.sv
// Shift-count register with captured fallback count from the register operand.
module shl_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [CW-1:0] imm_i,
  input  logic [CW-1:0] reg_low_i,
  input  logic          ld_reg_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_zero_o,
  output logic          imm_zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] alt_q;

  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign imm_zero_o = (imm_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alt_q <= '0;
    end else if (accept_i) begin
      cnt_q <= imm_i;
      alt_q <= reg_low_i;
    end else if (ld_reg_i) begin
      cnt_q <= alt_q;
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/shl_data.sv
// Working value register, single-position left shift and result register.
module shl_data #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic [W-1:0] operand_i,
  input  logic         step_i,
  input  logic         write_i,
  output logic [W-1:0] value_o,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  logic [W-1:0] value_q;
  logic [W-1:0] moved;
  logic [W-1:0] result_q;
  logic         done_q;

  assign moved[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_lane
    assign moved[i] = value_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= write_i;
      if (accept_i)    value_q <= operand_i;
      else if (step_i) value_q <= moved;
      if (write_i)     result_q <= value_q;
    end
  end

  assign value_o  = value_q;
  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/shl_engine.sv
module shl_engine
  import shl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [W-1:0]         operand_i,
  input  logic [$clog2(W)-1:0] imm_cnt_i,
  input  logic [W-1:0]         reg_cnt_i,
  output logic                 done_o,
  output logic [W-1:0]         result_o
);
  localparam int CW = $clog2(W);

  shl_state_e    state_w;
  logic          accept_w, ld_reg_w, step_w, write_w;
  logic          imm_zero_w, cnt_zero_w;
  logic [CW-1:0] cnt_w;
  logic [W-1:0]  value_w;
  logic          unused_hi;

  assign unused_hi = ^reg_cnt_i[W-1:CW];

  shl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .imm_zero_i(imm_zero_w), .cnt_zero_i(cnt_zero_w),
    .state_o(state_w), .accept_o(accept_w), .ld_reg_o(ld_reg_w),
    .step_o(step_w), .write_o(write_w)
  );

  shl_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w),
    .imm_i(imm_cnt_i), .reg_low_i(reg_cnt_i[CW-1:0]),
    .ld_reg_i(ld_reg_w), .step_i(step_w),
    .cnt_o(cnt_w), .cnt_zero_o(cnt_zero_w), .imm_zero_o(imm_zero_w)
  );

  shl_data #(.W(W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .operand_i(operand_i),
    .step_i(step_w), .write_i(write_w),
    .value_o(value_w), .result_o(result_o), .done_o(done_o)
  );
endmodule

// File: rtl/shl_engine_chk.sv
module shl_engine_chk
  import shl_pkg::*;
#(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done_o,
  input logic [W-1:0]         result_o,
  input shl_state_e           state,
  input logic [$clog2(W)-1:0] cnt,
  input logic [W-1:0]         value
);
  localparam int CW = $clog2(W);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |=> done_o);

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOADR || state == ST_TEST || state == ST_STEP) |=> (state != ST_IDLE));

  a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP) |=> (cnt == CW'($past(cnt) - 1'b1)));

  a_r5_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEST && cnt == '0) |=> (state == ST_WRITE));

  a_r5_nonzero_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEST && cnt != '0) |=> (state == ST_STEP));

  a_r4_one_place: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP) |=> (value == {$past(value[W-2:0]), 1'b0}));
endmodule

bind shl_engine shl_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .result_o(result_o),
  .state(state_w), .cnt(cnt_w), .value(value_w)
);

// File: tb/shl_engine_test.sv
module shl_engine_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_in = '0;
  logic [4:0]  imm_in = '0;
  logic [31:0] reg_in = '0;
  logic        done;
  logic [31:0] res;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  shl_engine #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .operand_i(op_in),
    .imm_cnt_i(imm_in), .reg_cnt_i(reg_in), .done_o(done), .result_o(res)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_res(input logic [31:0] op, input logic [4:0] imm, input logic [31:0] rg);
    logic [4:0] n;
    n = (imm != 0) ? imm : rg[4:0];
    return op << n;
  endfunction

  function automatic int exp_lat(input logic [4:0] imm, input logic [31:0] rg);
    if (imm != 0) return 2 * int'(imm) + 2;
    return 2 * int'(rg[4:0]) + 3;
  endfunction

  // mode 0: quiet; 1: scramble inputs mid-run; 2: scramble and pulse start mid-run
  task automatic run_op(input logic [31:0] op, input logic [4:0] imm, input logic [31:0] rg,
                        input int mode, output logic [31:0] r, output int lat, output bit pulse_ok);
    @(negedge clk);
    op_in = op; imm_in = imm; reg_in = rg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 3) start = 1'b0;
      if (mode != 0 && lat == 1) begin
        op_in = ~op; imm_in = imm ^ 5'd9; reg_in = ~rg;
      end
      if (mode == 2 && lat == 2) start = 1'b1;
    end while (!done && lat < 300);
    start = 1'b0;
    r = res;
    @(negedge clk);
    pulse_ok = !done && (res == r);
  endtask

  task automatic do_case(input string tag, input logic [31:0] op, input logic [4:0] imm,
                         input logic [31:0] rg, input int mode);
    logic [31:0] r;
    int lat;
    bit pulse_ok;
    run_op(op, imm, rg, mode, r, lat, pulse_ok);
    check(r == exp_res(op, imm, rg), {tag, " result"}, r, exp_res(op, imm, rg));
    check(lat == exp_lat(imm, rg), {tag, " latency"}, lat, exp_lat(imm, rg));
    check(pulse_ok, {tag, " R7 one-cycle done"}, {31'd0, pulse_ok}, 32'd1);
  endtask

  task automatic t_reset();
    #(PERIOD * 2);
    check(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
    check(res == '0, "R1 result in reset", res, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && res == '0, "R1 after release", res, 32'd0);
  endtask

  task automatic t_imm_counts();
    do_case("R2 R4 R5 imm=1", 32'h0000_0001, 5'd1, 32'hFFFF_FFFF, 0);
    do_case("R2 R4 R5 imm=31", 32'hA5A5_0F0F, 5'd31, 32'h0000_0004, 0);
    do_case("R2 R4 R5 imm=7", 32'h8000_0001, 5'd7, 32'h0000_0010, 0);
    do_case("R2 R4 imm=16", 32'hFFFF_FFFF, 5'd16, 32'h0000_0000, 0);
  endtask

  task automatic t_reg_counts();
    do_case("R3 R5 reg low=3", 32'h0000_1234, 5'd0, 32'hFFFF_FFE3, 0);
    do_case("R3 reg low=31", 32'h0000_0003, 5'd0, 32'h0000_007F, 0);
  endtask

  task automatic t_zero_count();
    do_case("R6 zero count", 32'hDEAD_BEEF, 5'd0, 32'hFFFF_FFE0, 0);
  endtask

  task automatic t_busy_start();
    do_case("R9 start while busy", 32'h0F00_00F1, 5'd4, 32'h0, 2);
    do_case("R9 start while busy reg", 32'h1357_9BDF, 5'd0, 32'h0000_0002, 2);
  endtask

  task automatic t_input_change();
    do_case("R10 inputs changed", 32'h0000_00FF, 5'd5, 32'h0000_001E, 1);
  endtask

  task automatic t_hold();
    logic [31:0] r0;
    bit stable_ok = 1'b1;
    r0 = res;
    op_in = 32'h5555_5555; imm_in = 5'd3;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (res != r0 || done) stable_ok = 1'b0;
    end
    check(stable_ok, "R8 result held while idle", res, r0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_imm_counts();
    t_reg_counts();
    t_zero_count();
    t_busy_start();
    t_input_change();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule